// File: doc/BRIEF.md
# Multi-Bank Chip-Select Memory Sequencer

This block decodes bus requests against eight programmable memory regions and runs the strobe sequence for an external asynchronous memory. Each region, or bank, has a base address, a block-size mask, a data port width, a wait-state count and a write-protect flag. When a request arrives the block picks the matching bank, raises that bank's chip select together with the output-enable line or the byte write enables, and holds them for the programmed number of wait states. It then returns a one-cycle acknowledge.

A write to a protected bank, or a request that hits no bank, drives no strobes and returns a one-cycle transfer-error pulse. Bank 0 is usable straight out of reset as a boot region: it covers the whole address space, uses the slowest timing, and takes its port width from strap inputs. Software reprograms every bank through a small register port, writing one word per access.

Top module: `bank_cs_ctrl`

## Requirements
- R1: During reset (rstN low, sampled synchronously) bank 0 becomes valid with an all-zero compare mask, so it matches every address. It gets 15 wait states, write protection off, and a port width loaded from strapWidth. All other banks become invalid. After reset every output is low.
- R2: A bank matches when it is valid and (reqAddr[31:15] & mask) equals (base & mask). When several banks match, the lowest-numbered one is chosen.
- R3: For an accepted request with W wait states, the chosen chip select is high from the first cycle after the request edge through cycle W+2. ack is high only in cycle W+2.
- R4: ack lasts exactly one cycle, and all chip selects are low in the cycle that follows it.
- R5: A write to a write-protected bank raises no chip select and no write enable. Instead xferErr is high for exactly the one cycle after the request edge. A read from that bank runs normally.
- R6: A request that matches no bank gives the same one-cycle xferErr response and drives no strobes.
- R7: On a 32-bit bank (width code 2 or 3), we bit n enables byte lane n, where lane 0 is address byte 0. A byte write enables lane reqAddr[1:0]. A halfword write enables 4'b0011, or 4'b1100 when reqAddr[1] is 1. A word write (reqSize 2 or 3) enables 4'b1111. reqSize codes are 0 for byte, 1 for halfword and 2 for word.
- R8: On a 16-bit bank (width code 1), a byte write enables lane reqAddr[0] and any wider write enables 4'b0011. On an 8-bit bank (width code 0), every write enables only 4'b0001.
- R9: oe is high only during reads, and we is non-zero only during writes. Both follow the chip select window.
- R10: At most one chip select is high at any time.
- R11: A config write (cfgWe high) with cfgSel 0 loads bank cfgBank's base from cfgData[31:15] and its valid flag from cfgData[0]. With cfgSel 1 it loads the mask from cfgData[31:15], the wait count from cfgData[6:3], the width code from cfgData[2:1] and write protection from cfgData[0].
- R12: reqValid is ignored while an access or an error response is in progress. The ongoing chip select, acknowledge timing and error output are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| strapWidth | input | 2 | Boot bank width code, loaded during reset |
| cfgWe | input | 1 | Config register write strobe |
| cfgBank | input | 3 | Bank index for the config write |
| cfgSel | input | 1 | 0 selects the base word, 1 selects the option word |
| cfgData | input | 32 | Config write data |
| reqValid | input | 1 | Request strobe, accepted only when idle |
| reqAddr | input | 32 | Request address |
| reqWrite | input | 1 | 1 for a write, 0 for a read |
| reqSize | input | 2 | Transfer size code |
| chipSel | output | 8 | Per-bank chip selects, active high |
| oe | output | 1 | Output enable for reads |
| we | output | 4 | Byte-lane write enables |
| ack | output | 1 | One-cycle completion pulse |
| xferErr | output | 1 | One-cycle transfer-error pulse |

## Verification
The strobes are due in the first cycle after the request edge and the error pulse in that same cycle. The acknowledge is due W+2 cycles after the request edge, and the chip-select release one cycle later. The bench drives the request at a falling edge and samples every output at later falling edges. It counts the falling edges until ack appears and compares that count with W+2 from the vector table. The busy-ignore test places a second request inside the wait window and checks that this count does not move.

// File: rtl/bank_cs_pkg.sv
package bank_cs_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACCESS = 2'd1,
    ST_DONE   = 2'd2,
    ST_ERR    = 2'd3
  } seqState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;    // latch bank, direction, lanes and wait count
    logic countDown;  // decrement the wait counter
    logic drive;      // chip select window open
  } ctlStrobe_t;

  // Byte lane enables for a given port width code and transfer size
  function automatic logic [3:0] laneMask(input logic [1:0] widthCode,
                                          input logic [1:0] sizeCode,
                                          input logic [1:0] lowAddr);
    logic [3:0] m;
    case (widthCode)
      2'd0:    m = 4'b0001;
      2'd1:    m = (sizeCode == 2'd0) ? (lowAddr[0] ? 4'b0010 : 4'b0001) : 4'b0011;
      default: begin
        if (sizeCode == 2'd0)      m = 4'b0001 << lowAddr;
        else if (sizeCode == 2'd1) m = lowAddr[1] ? 4'b1100 : 4'b0011;
        else                       m = 4'b1111;
      end
    endcase
    return m;
  endfunction

endpackage

// File: rtl/bank_cs_datapath.sv
module bank_cs_datapath
  import bank_cs_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int ADDR_W    = 32,
  parameter int BLK_LSB   = 15,
  parameter int WAIT_W    = 4
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [1:0]                   strapWidth,
  input  logic                         cfgWe,
  input  logic [$clog2(NUM_BANKS)-1:0] cfgBank,
  input  logic                         cfgSel,
  input  logic [ADDR_W-1:0]            cfgData,
  input  logic [ADDR_W-1:0]            reqAddr,
  input  logic                         reqWrite,
  input  logic [1:0]                   reqSize,
  input  ctlStrobe_t                   strobe,
  output logic                         hit,
  output logic                         blocked,
  output logic                         cntZero,
  output logic [NUM_BANKS-1:0]         chipSel,
  output logic                         oe,
  output logic [3:0]                   we
);

  localparam int TAG_W = ADDR_W - BLK_LSB;
  localparam int IDX_W = $clog2(NUM_BANKS);

  logic [NUM_BANKS-1:0]             bankHit;
  logic [NUM_BANKS-1:0]             protAll;
  logic [NUM_BANKS-1:0][WAIT_W-1:0] waitsAll;
  logic [NUM_BANKS-1:0][1:0]        widthAll;

  logic [TAG_W-1:0] reqTag;
  assign reqTag = reqAddr[ADDR_W-1:BLK_LSB];

  for (genvar g = 0; g < NUM_BANKS; g++) begin : gBank
    logic [TAG_W-1:0]  baseTag;
    logic [TAG_W-1:0]  maskTag;
    logic              valid;
    logic              wprot;
    logic [WAIT_W-1:0] waits;
    logic [1:0]        width;
    logic              sel;

    assign sel = cfgWe && (cfgBank == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        baseTag <= '0;
        maskTag <= '0;
        wprot   <= 1'b0;
        if (g == 0) begin
          valid <= 1'b1;
          waits <= '1;
          width <= strapWidth;
        end else begin
          valid <= 1'b0;
          waits <= '0;
          width <= 2'd2;
        end
      end else if (sel) begin
        if (!cfgSel) begin
          baseTag <= cfgData[ADDR_W-1:BLK_LSB];
          valid   <= cfgData[0];
        end else begin
          maskTag <= cfgData[ADDR_W-1:BLK_LSB];
          waits   <= cfgData[3 +: WAIT_W];
          width   <= cfgData[2:1];
          wprot   <= cfgData[0];
        end
      end
    end

    assign bankHit[g]  = valid && ((reqTag & maskTag) == (baseTag & maskTag));
    assign protAll[g]  = wprot;
    assign waitsAll[g] = waits;
    assign widthAll[g] = width;
  end

  // Lowest index wins
  logic [IDX_W-1:0] selIdx;
  always_comb begin
    hit    = 1'b0;
    selIdx = '0;
    for (int i = NUM_BANKS - 1; i >= 0; i--) begin
      if (bankHit[i]) begin
        hit    = 1'b1;
        selIdx = IDX_W'(i);
      end
    end
  end

  assign blocked = hit && reqWrite && protAll[selIdx];

  logic [IDX_W-1:0]  curIdx;
  logic              curWrite;
  logic [3:0]        curLanes;
  logic [WAIT_W-1:0] waitCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curIdx   <= '0;
      curWrite <= 1'b0;
      curLanes <= '0;
      waitCnt  <= '0;
    end else if (strobe.capture) begin
      curIdx   <= selIdx;
      curWrite <= reqWrite;
      curLanes <= laneMask(widthAll[selIdx], reqSize, reqAddr[1:0]);
      waitCnt  <= waitsAll[selIdx];
    end else if (strobe.countDown) begin
      waitCnt  <= waitCnt - 1'b1;
    end
  end

  assign cntZero = (waitCnt == '0);
  assign chipSel = strobe.drive ? (NUM_BANKS'(1) << curIdx) : '0;
  assign oe      = strobe.drive && !curWrite;
  assign we      = (strobe.drive && curWrite) ? curLanes : 4'b0000;

endmodule

// File: rtl/bank_cs_control.sv
module bank_cs_control
  import bank_cs_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       hit,
  input  logic       blocked,
  input  logic       cntZero,
  output ctlStrobe_t strobe,
  output logic       ack,
  output logic       xferErr
);

  seqState_t state;
  logic      accept;

  assign accept = (state == ST_IDLE) && reqValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else begin
      case (state)
        ST_IDLE:   if (reqValid) state <= (hit && !blocked) ? ST_ACCESS : ST_ERR;
        ST_ACCESS: if (cntZero) state <= ST_DONE;
        ST_DONE:   state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.capture   = accept && hit && !blocked;
    strobe.countDown = (state == ST_ACCESS) && !cntZero;
    strobe.drive     = (state == ST_ACCESS) || (state == ST_DONE);
  end

  assign ack     = (state == ST_DONE);
  assign xferErr = (state == ST_ERR);

endmodule

// File: rtl/bank_cs_ctrl.sv
module bank_cs_ctrl
  import bank_cs_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int ADDR_W    = 32,
  parameter int BLK_LSB   = 15,
  parameter int WAIT_W    = 4
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [1:0]                   strapWidth,
  input  logic                         cfgWe,
  input  logic [$clog2(NUM_BANKS)-1:0] cfgBank,
  input  logic                         cfgSel,
  input  logic [ADDR_W-1:0]            cfgData,
  input  logic                         reqValid,
  input  logic [ADDR_W-1:0]            reqAddr,
  input  logic                         reqWrite,
  input  logic [1:0]                   reqSize,
  output logic [NUM_BANKS-1:0]         chipSel,
  output logic                         oe,
  output logic [3:0]                   we,
  output logic                         ack,
  output logic                         xferErr
);

  ctlStrobe_t strobe;
  logic       hit;
  logic       blocked;
  logic       cntZero;

  bank_cs_control uCtl (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .hit     (hit),
    .blocked (blocked),
    .cntZero (cntZero),
    .strobe  (strobe),
    .ack     (ack),
    .xferErr (xferErr)
  );

  bank_cs_datapath #(
    .NUM_BANKS(NUM_BANKS),
    .ADDR_W   (ADDR_W),
    .BLK_LSB  (BLK_LSB),
    .WAIT_W   (WAIT_W)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strapWidth(strapWidth),
    .cfgWe     (cfgWe),
    .cfgBank   (cfgBank),
    .cfgSel    (cfgSel),
    .cfgData   (cfgData),
    .reqAddr   (reqAddr),
    .reqWrite  (reqWrite),
    .reqSize   (reqSize),
    .strobe    (strobe),
    .hit       (hit),
    .blocked   (blocked),
    .cntZero   (cntZero),
    .chipSel   (chipSel),
    .oe        (oe),
    .we        (we)
  );

endmodule

// File: rtl/bank_cs_ctrl_chk.sv
module bank_cs_ctrl_chk #(
  parameter int NUM_BANKS = 8
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [NUM_BANKS-1:0] chipSel,
  input logic                 oe,
  input logic [3:0]           we,
  input logic                 ack,
  input logic                 xferErr
);

  p_cs_onehot_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(chipSel));

  p_ack_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    ack |=> !ack);

  p_cs_release_r4: assert property (@(posedge clk) disable iff (!rstN)
    ack |=> (chipSel == '0));

  p_ack_in_window_r3: assert property (@(posedge clk) disable iff (!rstN)
    ack |-> (chipSel != '0));

  p_err_quiet_r5: assert property (@(posedge clk) disable iff (!rstN)
    xferErr |-> ((chipSel == '0) && (we == 4'b0000) && !oe && !ack));

  p_err_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    xferErr |=> !xferErr);

  p_dir_excl_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(oe && (we != 4'b0000)));

  p_strobe_needs_cs_r9: assert property (@(posedge clk) disable iff (!rstN)
    (oe || (we != 4'b0000)) |-> (chipSel != '0));

endmodule

bind bank_cs_ctrl bank_cs_ctrl_chk #(.NUM_BANKS(NUM_BANKS)) uChk (
  .clk    (clk),
  .rstN   (rstN),
  .chipSel(chipSel),
  .oe     (oe),
  .we     (we),
  .ack    (ack),
  .xferErr(xferErr)
);

// File: tb/sim_bank_cs_ctrl.sv
module sim_bank_cs_ctrl;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  strapWidth = 2'd1;
  logic        cfgWe = 1'b0;
  logic [2:0]  cfgBank = '0;
  logic        cfgSel = 1'b0;
  logic [31:0] cfgData = '0;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic        reqWrite = 1'b0;
  logic [1:0]  reqSize = '0;
  logic [7:0]  chipSel;
  logic        oe;
  logic [3:0]  we;
  logic        ack;
  logic        xferErr;

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;  // 50 MHz

  bank_cs_ctrl u0 (
    .clk(clk), .rstN(rstN), .strapWidth(strapWidth),
    .cfgWe(cfgWe), .cfgBank(cfgBank), .cfgSel(cfgSel), .cfgData(cfgData),
    .reqValid(reqValid), .reqAddr(reqAddr), .reqWrite(reqWrite), .reqSize(reqSize),
    .chipSel(chipSel), .oe(oe), .we(we), .ack(ack), .xferErr(xferErr)
  );

  typedef struct packed {
    logic [31:0] addr;
    logic        wr;
    logic [1:0]  size;
    logic [7:0]  cs;
    logic [3:0]  weExp;
    logic        oeExp;
    logic        err;
    logic [3:0]  waits;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_0010, 1'b0, 2'd2, 8'h01, 4'h0, 1'b1, 1'b0, 4'd0},  // R9 read, R2 bank0
    '{32'h0000_0011, 1'b1, 2'd0, 8'h01, 4'h2, 1'b0, 1'b0, 4'd0},  // R7 byte lane 1
    '{32'h0000_0012, 1'b1, 2'd1, 8'h01, 4'hC, 1'b0, 1'b0, 4'd0},  // R7 upper half
    '{32'h0000_0003, 1'b1, 2'd0, 8'h01, 4'h8, 1'b0, 1'b0, 4'd0},  // R7 byte lane 3
    '{32'h0000_0000, 1'b1, 2'd2, 8'h01, 4'hF, 1'b0, 1'b0, 4'd0},  // R7 word
    '{32'h1000_0040, 1'b0, 2'd2, 8'h02, 4'h0, 1'b1, 1'b0, 4'd3},  // R5 protected read ok
    '{32'h1000_0040, 1'b1, 2'd2, 8'h00, 4'h0, 1'b0, 1'b1, 4'd0},  // R5 protected write
    '{32'h2000_1003, 1'b1, 2'd0, 8'h04, 4'h2, 1'b0, 1'b0, 4'd1},  // R2 priority, R8 16-bit
    '{32'h2000_1002, 1'b1, 2'd1, 8'h04, 4'h3, 1'b0, 1'b0, 4'd1},  // R8 16-bit half
    '{32'h2010_0003, 1'b1, 2'd0, 8'h08, 4'h1, 1'b0, 1'b0, 4'd2},  // R8 8-bit byte
    '{32'h2010_0000, 1'b1, 2'd2, 8'h08, 4'h1, 1'b0, 1'b0, 4'd2},  // R8 8-bit word
    '{32'h5000_0000, 1'b0, 2'd2, 8'h00, 4'h0, 1'b0, 1'b1, 4'd0},  // R6 no match
    '{32'h0000_8000, 1'b1, 2'd2, 8'h00, 4'h0, 1'b0, 1'b1, 4'd0},  // R6 past bank0 size
    '{32'h2010_0002, 1'b0, 2'd1, 8'h08, 4'h0, 1'b1, 1'b0, 4'd2}   // R9 read on 8-bit
  };

  function automatic string tagOf(input vec_t v);
    if (v.err)                          return "R5/R6";
    if (v.cs == 8'h02)                  return "R5";
    if (v.cs == 8'h04 || v.cs == 8'h08) return "R2/R8";
    return "R7/R9";
  endfunction

  function automatic logic [31:0] baseWord(input logic [31:0] base, input logic v);
    return {base[31:15], 14'b0, v};
  endfunction

  function automatic logic [31:0] optWord(input logic [16:0] mask, input logic [3:0] w,
                                          input logic [1:0] width, input logic wp);
    return {mask, 8'b0, w, width, wp};
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [2:0] b, input logic s, input logic [31:0] d);
    @(negedge clk);
    cfgWe = 1'b1; cfgBank = b; cfgSel = s; cfgData = d;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic runReq(input vec_t v, input string tag);
    int k;
    @(negedge clk);
    reqValid = 1'b1; reqAddr = v.addr; reqWrite = v.wr; reqSize = v.size;
    @(negedge clk);
    reqValid = 1'b0;
    if (v.err) begin
      chk(xferErr == 1'b1, tag, "xferErr", 32'(xferErr), 1);
      chk(chipSel == 8'h00 && we == 4'h0 && !ack, tag, "quiet strobes",
          {20'b0, chipSel, we}, 0);
      @(negedge clk);
      chk(xferErr == 1'b0, tag, "xferErr pulse", 32'(xferErr), 0);
    end else begin
      chk(chipSel == v.cs, tag, "chipSel", 32'(chipSel), 32'(v.cs));
      chk(we == v.weExp, tag, "we", 32'(we), 32'(v.weExp));
      chk(oe == v.oeExp, tag, "oe", 32'(oe), 32'(v.oeExp));
      k = 1;
      while (!ack && k < 40) begin
        @(negedge clk);
        k++;
      end
      chk(k == int'(v.waits) + 2, "R3", "ack cycle", 32'(k), 32'(int'(v.waits) + 2));
      chk(chipSel == v.cs, "R3", "cs during ack", 32'(chipSel), 32'(v.cs));
      @(negedge clk);
      chk(chipSel == 8'h00 && !ack, "R4", "release after ack",
          {23'b0, ack, chipSel}, 0);
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    vec_t d;
    int k;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: idle outputs after reset
    chk(chipSel == 8'h00 && !oe && we == 4'h0 && !ack && !xferErr, "R1", "idle outputs",
        {21'b0, ack, xferErr, oe, chipSel}, 0);
    // R1: boot bank catches all, 16-bit strap, 15 waits
    runReq('{32'h1234_5678, 1'b1, 2'd2, 8'h01, 4'h3, 1'b0, 1'b0, 4'd15}, "R1");

    // R11: program banks
    cfgWrite(3'd0, 1'b0, baseWord(32'h0000_0000, 1'b1));
    cfgWrite(3'd0, 1'b1, optWord(17'h1FFFF, 4'd0, 2'd2, 1'b0));
    cfgWrite(3'd1, 1'b0, baseWord(32'h1000_0000, 1'b1));
    cfgWrite(3'd1, 1'b1, optWord(17'h1E000, 4'd3, 2'd2, 1'b1));
    cfgWrite(3'd2, 1'b0, baseWord(32'h2000_0000, 1'b1));
    cfgWrite(3'd2, 1'b1, optWord(17'h1FFE0, 4'd1, 2'd1, 1'b0));
    cfgWrite(3'd3, 1'b0, baseWord(32'h2000_0000, 1'b1));
    cfgWrite(3'd3, 1'b1, optWord(17'h1E000, 4'd2, 2'd0, 1'b0));

    for (int i = 0; i < NV; i++) runReq(VECS[i], tagOf(VECS[i]));

    // R12: second request during a wait window is ignored
    @(negedge clk);
    reqValid = 1'b1; reqAddr = 32'h1000_0000; reqWrite = 1'b0; reqSize = 2'd2;
    @(negedge clk);
    reqAddr = 32'h5000_0000; reqWrite = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    chk(!xferErr && chipSel == 8'h02, "R12", "busy ignore",
        {23'b0, xferErr, chipSel}, 32'h02);
    k = 2;
    while (!ack && k < 40) begin
      @(negedge clk);
      k++;
    end
    chk(k == 5, "R12", "ack cycle unchanged", 32'(k), 5);
    @(negedge clk);
    chk(chipSel == 8'h00 && !xferErr, "R12", "no late response",
        {23'b0, xferErr, chipSel}, 0);

    // R11/R2: invalidating bank 2 hands the overlap to bank 3
    cfgWrite(3'd2, 1'b0, baseWord(32'h2000_0000, 1'b0));
    d = '{32'h2000_1003, 1'b1, 2'd0, 8'h08, 4'h1, 1'b0, 1'b0, 4'd2};
    runReq(d, "R11/R2");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule